// File: doc/BRIEF.md
# End-of-Interrupt Broadcast Handler

This block sits next to an interrupt redirection table. When an end-of-interrupt arrives carrying a vector number, it scans every redirection entry in turn, one entry per clock. An entry is touched only when three things hold: it is level-triggered, its remote-IRR bit is set, and its vector equals the EOI vector. Such an entry has its remote-IRR bit cleared by a read-modify-write on the table port. If that entry is also unmasked and its input pin is still pending, a service pass is requested. The message generation that follows the request lies outside this block.

A counter per vector watches for an interrupt storm: an interrupt that is re-asserted at once after every EOI. Each immediate re-assertion on a vector adds one to its counter, and any hit that does not re-assert returns it to zero. When the counter reaches its limit it clears itself. The re-service is then handed to a tick-driven timer, so it does not happen at once. A deferral that arrives while another is pending never pushes the pending deadline out.

Top module: `eoi_broadcast_unit`

## Requirements
- R1: An accepted EOI (`eoi_valid` high while `busy` is low) raises `busy` on the next clock for exactly NUM_ENTRIES cycles. During those cycles `tbl_idx` steps 0, 1, ... NUM_ENTRIES-1, one entry per cycle.
- R2: An EOI presented while `busy` is high is dropped. It changes no entry and requests no service.
- R3: An entry is a hit only if bits [7:0] equal the EOI vector, bit 15 (trigger, 1 = level) is 1 and bit 14 (remote-IRR) is 1. The block writes no other entry.
- R4: For a hit, `tbl_we` is high in that entry's cycle. `tbl_wdata` equals the read entry with bit 14 cleared, and every other bit is unchanged.
- R5: If a hit has bit 16 (mask) at 0 and its `pend` bit at 1, the vector's counter increments. While the new count stays below STORM_LIMIT, `svc_req` pulses for one cycle, in the cycle after the entry's cycle, once for each such hit.
- R6: If a hit is masked or not pending, the vector's counter returns to zero and no service is requested.
- R7: When an increment would bring the counter to STORM_LIMIT, the counter goes to zero, no immediate request is made, and a deferred service is armed for DELAY_TICKS timer ticks.
- R8: An armed deferral counts only `tick` pulses. On the DELAY_TICKS-th tick, `svc_req` pulses once in the next cycle. Cycles without a tick do not advance it.
- R9: A deferral armed while another is pending keeps the earlier, shorter deadline and adds no second request.
- R10: After reset, `busy`, `tbl_we` and `svc_req` are low, every vector counter is zero and no deferral is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vector | input | 8 | Vector being retired |
| busy | output | 1 | Walk in progress; new EOIs are dropped |
| tbl_idx | output | $clog2(NUM_ENTRIES) | Index of the entry being examined |
| tbl_rdata | input | 64 | Entry at `tbl_idx`, read combinationally |
| tbl_we | output | 1 | Write-back strobe for the entry at `tbl_idx` |
| tbl_wdata | output | 64 | Entry value to write back |
| pend | input | NUM_ENTRIES | Pending state of each input pin |
| tick | input | 1 | Timer tick for deferred service |
| svc_req | output | 1 | One-cycle request for a service pass |

## Verification
The hardest state to reach is the storm path. The counter of one vector has to climb to STORM_LIMIT through consecutive pending, unmasked hits, and no zeroing hit may fall in between. A second deferral then has to land while the first is still counting down. The bench builds the bench with a small STORM_LIMIT and DELAY_TICKS and re-arms the remote-IRR bit of one entry before every EOI. It drives `tick` by hand, so it knows exactly how much of the first deadline is left when the second storm on another vector arrives. It then counts ticks up to the single resulting request.

// File: rtl/eoi_bcast_pkg.sv
package eoi_bcast_pkg;

  localparam int ENT_W    = 64;
  localparam int VEC_W    = 8;
  localparam int NUM_VEC  = 1 << VEC_W;
  localparam int RIRR_BIT = 14;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    logic             level;
    logic             rirr;
    logic             masked;
  } rte_view_t;

  function automatic rte_view_t rte_decode(input logic [ENT_W-1:0] e);
    rte_view_t v;
    v.vec    = e[VEC_W-1:0];
    v.level  = e[TRIG_BIT];
    v.rirr   = e[RIRR_BIT];
    v.masked = e[MASK_BIT];
    return v;
  endfunction

  function automatic logic rte_hit(input rte_view_t v, input logic [VEC_W-1:0] vec);
    return (v.vec == vec) && v.level && v.rirr;
  endfunction

  function automatic logic [ENT_W-1:0] rte_clear_rirr(input logic [ENT_W-1:0] e);
    logic [ENT_W-1:0] r;
    r = e;
    r[RIRR_BIT] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/eoi_walker.sv
module eoi_walker
  import eoi_bcast_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [VEC_W-1:0] start_vec,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] vec
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  typedef enum logic {ST_IDLE, ST_WALK} walk_st_t;

  walk_st_t         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;
  logic             accept;

  assign accept = start_req && (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      vec_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q  <= ST_WALK;
          idx_q <= '0;
          vec_q <= start_vec;
        end
        ST_WALK: begin
          if (idx_q == LAST_IDX) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q == ST_WALK);
  assign idx  = idx_q;
  assign vec  = vec_q;

endmodule

// File: rtl/eoi_storm_ctr.sv
module eoi_storm_ctr
  import eoi_bcast_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int STORM_LIMIT = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [VEC_W-1:0] upd_vec,
  input  logic             upd_inc,
  output logic             storm,
  output logic             fire_now,
  output logic [CNT_W-1:0] wr_val
);

  localparam logic [CNT_W:0] LIMIT_X = (CNT_W+1)'(STORM_LIMIT);

  logic [CNT_W-1:0] cnt_q [NUM_VEC];

  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] c);
    return {1'b0, c} + 1'b1;
  endfunction

  logic [CNT_W:0] inc_val;

  always_comb begin
    inc_val  = bump(cnt_q[upd_vec]);
    storm    = upd_en && upd_inc && (inc_val >= LIMIT_X);
    fire_now = upd_en && upd_inc && !storm;
    if (upd_inc && !storm) wr_val = inc_val[CNT_W-1:0];
    else                   wr_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VEC; v++) cnt_q[v] <= '0;
    end else if (upd_en) begin
      cnt_q[upd_vec] <= wr_val;
    end
  end

endmodule

// File: rtl/eoi_defer_timer.sv
module eoi_defer_timer #(
  parameter int DELAY_TICKS = 1000,
  localparam int TW = $clog2(DELAY_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          tick,
  output logic          expire,
  output logic [TW-1:0] left
);

  localparam logic [TW-1:0] FULL = TW'(DELAY_TICKS);

  logic [TW-1:0] left_q;
  logic          active;

  assign active = (left_q != '0);
  assign expire = tick && (left_q == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (expire) begin
      left_q <= '0;
    end else if (arm && (!active || FULL < left_q)) begin
      left_q <= FULL;
    end else if (tick && active) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign left = left_q;

endmodule

// File: rtl/eoi_broadcast_unit.sv
module eoi_broadcast_unit
  import eoi_bcast_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int CNT_W       = 14,
  parameter int STORM_LIMIT = 10000,
  parameter int DELAY_TICKS = 1000,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int TW    = $clog2(DELAY_TICKS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  output logic                   busy,
  output logic [IDX_W-1:0]       tbl_idx,
  input  logic [ENT_W-1:0]       tbl_rdata,
  output logic                   tbl_we,
  output logic [ENT_W-1:0]       tbl_wdata,
  input  logic [NUM_ENTRIES-1:0] pend,
  input  logic                   tick,
  output logic                   svc_req
);

  logic [VEC_W-1:0] walk_vec;
  rte_view_t        cur_view;
  logic             hit_w;
  logic             reassert_w;
  logic             storm_w;
  logic             fire_now_w;
  logic             expire_w;
  logic [CNT_W-1:0] cnt_wr_w;
  logic [TW-1:0]    tmr_left_w;
  logic             svc_q;

  eoi_walker #(.NUM_ENTRIES(NUM_ENTRIES)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (eoi_valid),
    .start_vec (eoi_vector),
    .busy      (busy),
    .idx       (tbl_idx),
    .vec       (walk_vec)
  );

  always_comb begin
    cur_view   = rte_decode(tbl_rdata);
    hit_w      = busy && rte_hit(cur_view, walk_vec);
    reassert_w = !cur_view.masked && pend[tbl_idx];
  end

  assign tbl_we    = hit_w;
  assign tbl_wdata = rte_clear_rirr(tbl_rdata);

  eoi_storm_ctr #(.CNT_W(CNT_W), .STORM_LIMIT(STORM_LIMIT)) u_storm (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (hit_w),
    .upd_vec  (walk_vec),
    .upd_inc  (reassert_w),
    .storm    (storm_w),
    .fire_now (fire_now_w),
    .wr_val   (cnt_wr_w)
  );

  eoi_defer_timer #(.DELAY_TICKS(DELAY_TICKS)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (storm_w),
    .tick   (tick),
    .expire (expire_w),
    .left   (tmr_left_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= 1'b0;
    else        svc_q <= fire_now_w || expire_w;
  end

  assign svc_req = svc_q;

endmodule

// File: rtl/eoi_broadcast_unit_chk.sv
module eoi_broadcast_unit_chk
  import eoi_bcast_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int CNT_W       = 14,
  parameter int STORM_LIMIT = 10000,
  parameter int DELAY_TICKS = 1000,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int TW    = $clog2(DELAY_TICKS + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic [IDX_W-1:0]       tbl_idx,
  input logic [ENT_W-1:0]       tbl_rdata,
  input logic                   tbl_we,
  input logic [ENT_W-1:0]       tbl_wdata,
  input logic [NUM_ENTRIES-1:0] pend,
  input logic                   tick,
  input logic                   svc_req,
  input logic [VEC_W-1:0]       walk_vec,
  input logic                   hit_w,
  input logic                   storm_w,
  input logic                   fire_now_w,
  input logic                   expire_w,
  input logic [CNT_W-1:0]       cnt_wr_w,
  input logic [TW-1:0]          tmr_left_w
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);
  localparam logic [ENT_W-1:0] KEEP_MSK = ~(ENT_W'(1) << RIRR_BIT);

  assert_start_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tbl_idx == '0);
  assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tbl_idx != LAST_IDX) |=> (busy && tbl_idx == $past(tbl_idx) + 1'b1));
  assert_walk_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tbl_idx == LAST_IDX) |=> !busy);
  assert_we_in_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> busy);
  assert_hit_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (tbl_rdata[TRIG_BIT] && tbl_rdata[RIRR_BIT] && tbl_rdata[VEC_W-1:0] == walk_vec));
  assert_clear_only_rirr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (!tbl_wdata[RIRR_BIT] && ((tbl_wdata & KEEP_MSK) == (tbl_rdata & KEEP_MSK))));
  assert_fire_needs_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_now_w |-> (hit_w && !tbl_rdata[MASK_BIT] && pend[tbl_idx]));
  assert_svc_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(fire_now_w || expire_w));
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |-> (32'(cnt_wr_w) < STORM_LIMIT));
  assert_storm_no_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    storm_w |-> !fire_now_w);
  assert_expire_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |-> tick);
  assert_left_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tmr_left_w) <= DELAY_TICKS);
  assert_no_extend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_left_w != '0 && !expire_w) |=> (tmr_left_w <= $past(tmr_left_w)));

endmodule

bind eoi_broadcast_unit eoi_broadcast_unit_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .CNT_W      (CNT_W),
  .STORM_LIMIT(STORM_LIMIT),
  .DELAY_TICKS(DELAY_TICKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .tbl_idx   (tbl_idx),
  .tbl_rdata (tbl_rdata),
  .tbl_we    (tbl_we),
  .tbl_wdata (tbl_wdata),
  .pend      (pend),
  .tick      (tick),
  .svc_req   (svc_req),
  .walk_vec  (walk_vec),
  .hit_w     (hit_w),
  .storm_w   (storm_w),
  .fire_now_w(fire_now_w),
  .expire_w  (expire_w),
  .cnt_wr_w  (cnt_wr_w),
  .tmr_left_w(tmr_left_w)
);

// File: tb/eoi_broadcast_unit_bench.sv
`timescale 1ns/1ps
module eoi_broadcast_unit_bench;

  localparam int N     = 24;
  localparam int LIMIT = 4;
  localparam int DLY   = 5;
  localparam int IW    = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vector = '0;
  logic          busy;
  logic [IW-1:0] tbl_idx;
  logic [63:0]   tbl_rdata;
  logic          tbl_we;
  logic [63:0]   tbl_wdata;
  logic [N-1:0]  pend = '0;
  logic          tick = 1'b0;
  logic          svc_req;

  logic [63:0]   tbl [N];
  logic          h_we = 1'b0;
  int            h_idx = 0;
  logic [63:0]   h_data = '0;

  int checks = 0;
  int errors = 0;
  int svc_seen = 0;

  always #4 clk = ~clk;

  eoi_broadcast_unit #(.NUM_ENTRIES(N), .CNT_W(14), .STORM_LIMIT(LIMIT), .DELAY_TICKS(DLY)) u_eoi_broadcast_unit (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .busy(busy), .tbl_idx(tbl_idx), .tbl_rdata(tbl_rdata), .tbl_we(tbl_we),
    .tbl_wdata(tbl_wdata), .pend(pend), .tick(tick), .svc_req(svc_req)
  );

  assign tbl_rdata = tbl[tbl_idx];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tbl[i] <= '0;
    end else if (tbl_we) begin
      tbl[tbl_idx] <= tbl_wdata;
    end else if (h_we) begin
      tbl[h_idx] <= h_data;
    end
  end

  always @(negedge clk) if (rst_n && svc_req) svc_seen++;

  // entry layout: vector [7:0], remote-IRR bit 14, level bit 15, mask bit 16
  function automatic logic [63:0] mk(input logic [7:0] v, input logic lvl,
                                     input logic rirr, input logic msk);
    return 64'hA5C3_0000_0000_0000 | {47'd0, msk, lvl, rirr, 6'd0, v};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_entry(input int i, input logic [63:0] d);
    @(negedge clk); h_we = 1'b1; h_idx = i; h_data = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic give_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 busy", busy, 0);
    chk("R10 tbl_we", tbl_we, 0);
    chk("R10 svc_req", svc_req, 0);
  endtask

  task automatic t_walk_len;
    int cyc = 0;
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h10;
    @(negedge clk); eoi_valid = 1'b0;
    while (busy) begin cyc++; @(negedge clk); end
    chk("R1 walk length", cyc, N);
  endtask

  task automatic t_basic;
    int s0;
    pend[3] = 1'b1;
    set_entry(3, mk(8'h41, 1, 1, 0));
    s0 = svc_seen;
    send_eoi(8'h41);
    chk("R4 rirr cleared, rest kept", tbl[3], mk(8'h41, 1, 0, 0));
    chk("R5 one immediate request", svc_seen - s0, 1);
    pend[3] = 1'b0;
  endtask

  task automatic t_non_hits;
    int s0;
    pend[6:4] = 3'b111; pend[7] = 1'b1;
    set_entry(4, mk(8'h50, 1, 1, 0));
    set_entry(6, mk(8'h51, 0, 1, 0));
    set_entry(7, mk(8'h51, 1, 0, 0));
    s0 = svc_seen;
    send_eoi(8'h51);
    chk("R3 vector mismatch untouched", tbl[4], mk(8'h50, 1, 1, 0));
    chk("R3 edge entry untouched", tbl[6], mk(8'h51, 0, 1, 0));
    chk("R3 rirr-clear entry untouched", tbl[7], mk(8'h51, 1, 0, 0));
    chk("R3 no request", svc_seen - s0, 0);
    set_entry(4, '0); set_entry(6, '0); set_entry(7, '0);
    pend = '0;
  endtask

  task automatic t_masked;
    int s0;
    pend[8] = 1'b1; pend[9] = 1'b0;
    set_entry(8, mk(8'h60, 1, 1, 1));
    set_entry(9, mk(8'h60, 1, 1, 0));
    s0 = svc_seen;
    send_eoi(8'h60);
    chk("R6 masked entry cleared", tbl[8], mk(8'h60, 1, 0, 1));
    chk("R6 idle-pin entry cleared", tbl[9], mk(8'h60, 1, 0, 0));
    chk("R6 no request", svc_seen - s0, 0);
    pend = '0;
  endtask

  task automatic t_multi;
    int s0;
    pend[0] = 1'b1; pend[N-1] = 1'b1;
    set_entry(0, mk(8'h70, 1, 1, 0));
    set_entry(N-1, mk(8'h70, 1, 1, 0));
    s0 = svc_seen;
    send_eoi(8'h70);
    chk("R5 first entry cleared", tbl[0], mk(8'h70, 1, 0, 0));
    chk("R5 last entry cleared", tbl[N-1], mk(8'h70, 1, 0, 0));
    chk("R5 two requests", svc_seen - s0, 2);
    set_entry(0, '0); set_entry(N-1, '0);
    pend = '0;
  endtask

  task automatic t_busy_drop;
    int s0;
    pend[5] = 1'b1;
    set_entry(5, mk(8'h22, 1, 1, 0));
    s0 = svc_seen;
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h11;
    @(negedge clk); eoi_vector = 8'h22;
    @(negedge clk); @(negedge clk); eoi_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R2 dropped EOI leaves entry", tbl[5], mk(8'h22, 1, 1, 0));
    chk("R2 dropped EOI no request", svc_seen - s0, 0);
    set_entry(5, '0);
    pend = '0;
  endtask

  task automatic storm_round(input int i, input logic [7:0] v);
    set_entry(i, mk(v, 1, 1, 0));
    send_eoi(v);
  endtask

  task automatic t_storm;
    int s0;
    pend[12] = 1'b1;
    s0 = svc_seen;
    for (int k = 0; k < LIMIT - 1; k++) storm_round(12, 8'h80);
    chk("R5 below limit immediate", svc_seen - s0, LIMIT - 1);
    s0 = svc_seen;
    storm_round(12, 8'h80);
    chk("R7 limit hit no immediate", svc_seen - s0, 0);
    chk("R7 entry still cleared", tbl[12], mk(8'h80, 1, 0, 0));
    repeat (30) @(negedge clk);
    chk("R8 no ticks no service", svc_seen - s0, 0);
    give_ticks(DLY - 1);
    chk("R8 early ticks no service", svc_seen - s0, 0);
    give_ticks(1);
    chk("R8 deferred service", svc_seen - s0, 1);
    s0 = svc_seen;
    storm_round(12, 8'h80);
    chk("R7 counter restarted", svc_seen - s0, 1);
    set_entry(12, '0);
    pend = '0;
  endtask

  task automatic t_zero_count;
    int s0;
    pend[13] = 1'b1;
    s0 = svc_seen;
    for (int k = 0; k < LIMIT - 1; k++) storm_round(13, 8'h90);
    pend[13] = 1'b0;
    storm_round(13, 8'h90);
    pend[13] = 1'b1;
    for (int k = 0; k < LIMIT - 1; k++) storm_round(13, 8'h90);
    chk("R6 idle hit zeroes count", svc_seen - s0, 2 * (LIMIT - 1));
    set_entry(13, '0);
    pend = '0;
  endtask

  task automatic t_no_extend;
    int s0;
    pend[14] = 1'b1; pend[15] = 1'b1;
    s0 = svc_seen;
    for (int k = 0; k < LIMIT; k++) storm_round(14, 8'hA0);
    give_ticks(2);
    for (int k = 0; k < LIMIT; k++) storm_round(15, 8'hB0);
    chk("R9 immediates before deferrals", svc_seen - s0, 2 * (LIMIT - 1));
    s0 = svc_seen;
    give_ticks(DLY - 3);
    chk("R9 not yet", svc_seen - s0, 0);
    give_ticks(1);
    chk("R9 earlier deadline kept", svc_seen - s0, 1);
    give_ticks(2 * DLY);
    chk("R9 no second request", svc_seen - s0, 1);
    pend = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_walk_len;
    t_basic;
    t_non_hits;
    t_masked;
    t_multi;
    t_busy_drop;
    t_storm;
    t_zero_count;
    t_no_extend;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule